// File: doc/BRIEF.md
# Half-Bridge Gate Sequencer

This block is the clocked control core of a synchronous buck power stage. It takes a PWM command that an input stage has already sorted into high, low or a mid-level tri-state band, and produces one enable for the high-side gate and one for the low-side gate. Between any two conduction states it enforces break-before-make. A device is switched on only after the opposite gate's sense flag reports that gate below roughly 1 V, and then only after a fixed number of further clock cycles. The dead time therefore follows the real gate discharge.

Several conditions override the PWM path. A tri-state command held long enough turns both gates off. An active-low disable and a supply-good flag from undervoltage lockout each clamp both outputs low in the same cycle. When diode emulation is enabled, the low side conducts after the PWM falls, and is cut at zero inductor current once a blanking window has elapsed. The hold-off, dead time and blanking window are parameters counted in clock cycles. All analog detection reaches the block as digital flags.

Top module: `hb_gate_ctrl`

## Requirements
- R1: During and right after reset both `hs_on` and `ls_on` are 0.
- R2: `hs_on` and `ls_on` are never 1 in the same cycle. After `pwm_lvl` changes from low to high, `ls_on` drops at the next clock edge. `hs_on` rises only after DT_CYC consecutive clock edges have each seen `ls_sense_low`=1 with the command still high.
- R3: The dead-time count restarts whenever the opposite gate's sense flag reads 0. A gate that stays above threshold therefore holds the incoming device off indefinitely.
- R4: After `pwm_lvl` changes from high to low, `hs_on` drops at the next edge. `ls_on` rises only after DT_CYC consecutive edges with `hs_sense_low`=1.
- R5: A tri-state command sampled on HOLD_CYC consecutive edges forces both outputs to 0 at the HOLD_CYC-th edge. Any shorter tri-state stretch leaves the outputs unchanged, and leaves any pending dead-time count frozen.
- R6: `dis_n`=0 forces both outputs to 0 in the same cycle and clears all pending timing. The outputs stay 0 at least until the clock edge after `dis_n` returns to 1.
- R7: `supply_ok`=0 behaves exactly like `dis_n`=0: an immediate clamp plus cleared timing.
- R8: With `zcd_en_n`=1 the low side stays on for as long as the command is low, whatever `zero_cur` reads.
- R9: With `zcd_en_n`=0, `zero_cur` is ignored on the first BLANK_CYC edges after `ls_on` rises. After that, `zero_cur`=1 at an edge turns `ls_on` off, and it stays off until the command goes high.
- R10: With `zcd_en_n`=0 and `zero_cur`=0, a tri-state command held for the hold-off time still turns `ls_on` off.
- R11: `pwm_lvl` encoding: 2'b00 is low, 2'b01 is high, and any value with bit 1 set (2'b10, 2'b11) is tri-state.
- R12: Leaving the off state, a tri-state timeout, a clamp or a zero-current cut always passes through the full dead-time sequence before a gate turns on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_lvl | input | 2 | Decoded PWM command (see R11) |
| dis_n | input | 1 | Active-low disable; an unconnected pin is expected to be tied to 0 |
| zcd_en_n | input | 1 | Active-low diode-emulation enable |
| supply_ok | input | 1 | Supply good from undervoltage lockout |
| hs_sense_low | input | 1 | High-side gate is below about 1 V |
| ls_sense_low | input | 1 | Low-side gate is below about 1 V |
| zero_cur | input | 1 | Inductor current is zero or negative |
| hs_on | output | 1 | High-side gate command |
| ls_on | output | 1 | Low-side gate command |

## Verification
The bench goes after the edges of every timed window. It checks the last tri-state cycle before hold-off expires, where a counter that is off by one would drop the gate a cycle early or late. It checks the last blanked cycle of diode emulation, where a short blank would cut the low side while current is still flowing. It holds one gate sense flag high while the command asks for the opposite device; a design that counts dead time from the command alone would then switch into a gate still on. After a clamp, a timeout and a zero-current cut, it checks that the next turn-on waits the full dead time; a design with a shortcut would turn on early. A model in the bench follows every cycle, so any stray toggle shows up as a mismatch.

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl #(
  parameter int HOLD_CYC  = 26,
  parameter int DT_CYC    = 3,
  parameter int BLANK_CYC = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pwm_lvl,
  input  logic       dis_n,
  input  logic       zcd_en_n,
  input  logic       supply_ok,
  input  logic       hs_sense_low,
  input  logic       ls_sense_low,
  input  logic       zero_cur,
  output logic       hs_on,
  output logic       ls_on
);
  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam int DW = $clog2(DT_CYC + 1);
  localparam int BW = $clog2(BLANK_CYC + 1);

  typedef enum logic [2:0] {S_OFF, S_HS, S_LS, S_ARMH, S_ARML, S_CUT} st_t;

  st_t           st;
  logic [HW-1:0] tri_cnt;
  logic [DW-1:0] dt_cnt;
  logic [BW-1:0] bl_cnt;

  wire cmd_hi  = (pwm_lvl == 2'b01);
  wire cmd_tri = pwm_lvl[1];
  wire kill    = !dis_n || !supply_ok;
  wire tri_to  = cmd_tri && (tri_cnt == HW'(HOLD_CYC - 1));
  wire dt_done = (dt_cnt == DW'(DT_CYC - 1));

  assign hs_on = (st == S_HS) && !kill;
  assign ls_on = (st == S_LS) && !kill;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                            tri_cnt <= '0;
    else if (!cmd_tri)                     tri_cnt <= '0;
    else if (tri_cnt != HW'(HOLD_CYC - 1)) tri_cnt <= tri_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_OFF;
      dt_cnt <= '0;
      bl_cnt <= '0;
    end else if (kill || tri_to) begin
      st     <= S_OFF;
      dt_cnt <= '0;
      bl_cnt <= '0;
    end else if (!cmd_tri) begin
      case (st)
        S_OFF: begin
          st     <= cmd_hi ? S_ARMH : S_ARML;
          dt_cnt <= '0;
        end
        S_HS:
          if (!cmd_hi) begin
            st     <= S_ARML;
            dt_cnt <= '0;
          end
        S_LS:
          if (cmd_hi) begin
            st     <= S_ARMH;
            dt_cnt <= '0;
          end else if (!zcd_en_n) begin
            if (bl_cnt != BW'(BLANK_CYC)) bl_cnt <= bl_cnt + 1'b1;
            else if (zero_cur)            st     <= S_CUT;
          end
        S_CUT:
          if (cmd_hi) begin
            st     <= S_ARMH;
            dt_cnt <= '0;
          end
        S_ARMH:
          if (!cmd_hi) begin
            st     <= S_ARML;
            dt_cnt <= '0;
          end else if (!ls_sense_low) dt_cnt <= '0;
          else if (dt_done)           st     <= S_HS;
          else                        dt_cnt <= dt_cnt + 1'b1;
        S_ARML:
          if (cmd_hi) begin
            st     <= S_ARMH;
            dt_cnt <= '0;
          end else if (!hs_sense_low) dt_cnt <= '0;
          else if (dt_done) begin
            st     <= S_LS;
            bl_cnt <= '0;
          end else dt_cnt <= dt_cnt + 1'b1;
        default: st <= S_OFF;
      endcase
    end
  end
endmodule

// File: rtl/hb_gate_ctrl_chk.sv
module hb_gate_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] pwm_lvl,
  input logic       dis_n,
  input logic       supply_ok,
  input logic       hs_sense_low,
  input logic       ls_sense_low,
  input logic       hs_on,
  input logic       ls_on
);
  p_no_overlap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_on && ls_on));

  p_hs_after_ls_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_on) |-> ($past(ls_sense_low) && $past(pwm_lvl) == 2'b01));

  p_ls_after_hs_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_on) |-> ($past(hs_sense_low) && $past(pwm_lvl) == 2'b00));

  // R7 shares this check: supply loss acts as a disable.
  p_clamp_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!dis_n || !supply_ok) |=> (!hs_on && !ls_on));

  p_turn_on_enabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hs_on) || $rose(ls_on)) |-> ($past(dis_n) && $past(supply_ok)));
endmodule

bind hb_gate_ctrl hb_gate_ctrl_chk u_chk (.*);

// File: tb/tb_hb_gate_ctrl.sv
module tb_hb_gate_ctrl;
  localparam int HOLD = 26, DT = 3, BLANK = 5;
  localparam int M_OFF = 0, M_HS = 1, M_LS = 2, M_AH = 3, M_AL = 4, M_CUT = 5;

  logic clk = 0;
  logic rst_n = 0;
  logic [1:0] pwm_lvl = 2'b10;
  logic dis_n = 1, zcd_en_n = 1, supply_ok = 1, zero_cur = 0;
  logic hold_ls_up = 0, hold_hs_up = 0;
  int   hs_quiet = 10, ls_quiet = 10;
  wire  hs_sense_low = (hs_quiet >= 2) && !hold_hs_up;
  wire  ls_sense_low = (ls_quiet >= 2) && !hold_ls_up;
  logic hs_on, ls_on;

  int total = 0, bad = 0;
  bit done = 0;
  string phase = "R1";
  int m_st = M_OFF, m_dt = 0, m_bl = 0, m_tri = 0;

  always #10 clk = ~clk;

  hb_gate_ctrl #(.HOLD_CYC(HOLD), .DT_CYC(DT), .BLANK_CYC(BLANK)) dut (
    .clk(clk), .rst_n(rst_n), .pwm_lvl(pwm_lvl), .dis_n(dis_n),
    .zcd_en_n(zcd_en_n), .supply_ok(supply_ok), .hs_sense_low(hs_sense_low),
    .ls_sense_low(ls_sense_low), .zero_cur(zero_cur), .hs_on(hs_on), .ls_on(ls_on));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // Reference model: advances on every rising edge from the sampled inputs.
  always @(posedge clk) begin
    bit tri_in, timeout, want_hi;
    if (!rst_n) begin
      m_st = M_OFF; m_dt = 0; m_bl = 0; m_tri = 0;
    end else begin
      tri_in  = pwm_lvl[1];
      want_hi = (pwm_lvl == 2'b01);
      timeout = tri_in && (m_tri == HOLD - 1);
      if (!dis_n || !supply_ok || timeout) begin
        m_st = M_OFF; m_dt = 0; m_bl = 0;
      end else if (!tri_in) begin
        if (m_st == M_OFF) begin
          m_st = want_hi ? M_AH : M_AL; m_dt = 0;
        end else if (want_hi && (m_st == M_LS || m_st == M_CUT || m_st == M_AL)) begin
          m_st = M_AH; m_dt = 0;
        end else if (!want_hi && (m_st == M_HS || m_st == M_AH)) begin
          m_st = M_AL; m_dt = 0;
        end else if (m_st == M_AH || m_st == M_AL) begin
          if (!(m_st == M_AH ? ls_sense_low : hs_sense_low)) m_dt = 0;
          else if (m_dt + 1 < DT) m_dt++;
          else begin
            m_st = (m_st == M_AH) ? M_HS : M_LS;
            m_bl = 0;
          end
        end else if (m_st == M_LS && !zcd_en_n) begin
          if (m_bl < BLANK) m_bl++;
          else if (zero_cur) m_st = M_CUT;
        end
      end
      m_tri = tri_in ? ((m_tri < HOLD - 1) ? m_tri + 1 : m_tri) : 0;
    end
  end

  // Compare every cycle, then update the gate-sense model.
  always @(negedge clk) begin
    int exp_v, act_v;
    bit en;
    if (!done) begin
      en    = dis_n && supply_ok;
      exp_v = {30'd0, (m_st == M_HS) && en, (m_st == M_LS) && en};
      act_v = {30'd0, hs_on, ls_on};
      chk(exp_v == act_v, phase, act_v, exp_v);
    end
    hs_quiet = hs_on ? 0 : hs_quiet + 1;
    ls_quiet = ls_on ? 0 : ls_quiet + 1;
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic look(input bit exp_hs, input bit exp_ls, input string tag);
    @(negedge clk);
    chk(hs_on == exp_hs && ls_on == exp_ls, tag, {hs_on, ls_on}, {exp_hs, exp_ls});
  endtask

  task automatic finish_run();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    step(3);
    look(0, 0, "R1 during reset");
    rst_n = 1;
    step(1);
    look(0, 0, "R1 after reset");

    phase = "R12";
    step(1); pwm_lvl = 2'b01;
    step(DT); look(0, 0, "R12 off exit waits dead time");
    step(1);  look(1, 0, "R2 high side after dead time");

    phase = "R4";
    pwm_lvl = 2'b00;
    step(1); look(0, 0, "R4 high side drops first");
    step(12); look(0, 1, "R4 low side on");

    phase = "R3";
    hold_ls_up = 1; pwm_lvl = 2'b01;
    step(10); look(0, 0, "R3 sense high holds off");
    hold_ls_up = 0;
    step(8); look(1, 0, "R3 resumes after sense");

    phase = "R5";
    pwm_lvl = 2'b10;
    step(10); look(1, 0, "R5 short tri keeps output");
    pwm_lvl = 2'b01;
    step(2);
    phase = "R11";
    pwm_lvl = 2'b11;
    step(HOLD - 1); look(1, 0, "R11 code 11 tri before hold-off");
    step(1); look(0, 0, "R11 code 11 tri timeout");
    phase = "R5";
    pwm_lvl = 2'b10;
    step(4); look(0, 0, "R5 stays off in tri");
    phase = "R12";
    pwm_lvl = 2'b01;
    step(DT); look(0, 0, "R12 tri exit waits dead time");
    step(1);  look(1, 0, "R12 tri exit on");

    phase = "R6";
    dis_n = 0;
    look(0, 0, "R6 same-cycle clamp");
    step(5); look(0, 0, "R6 held off");
    dis_n = 1;
    step(DT); look(0, 0, "R6 restart waits dead time");
    step(1);  look(1, 0, "R6 restart on");

    phase = "R7";
    supply_ok = 0;
    look(0, 0, "R7 same-cycle clamp");
    step(4);
    supply_ok = 1;
    step(DT); look(0, 0, "R7 restart waits dead time");
    step(1);  look(1, 0, "R7 restart on");

    phase = "R8";
    zero_cur = 1; pwm_lvl = 2'b00;
    step(30); look(0, 1, "R8 low side kept with detect off");

    phase = "R9";
    pwm_lvl = 2'b01; step(12);
    zcd_en_n = 0; pwm_lvl = 2'b00;
    do @(negedge clk); while (!ls_on);
    repeat (BLANK) @(posedge clk);
    look(0, 1, "R9 zero current ignored while blanked");
    @(posedge clk);
    look(0, 0, "R9 cut after blanking");
    #1 zero_cur = 0;
    step(10); look(0, 0, "R9 stays cut until high");
    pwm_lvl = 2'b01;
    step(DT); look(0, 0, "R12 cut exit waits dead time");
    step(1);  look(1, 0, "R12 cut exit on");

    phase = "R10";
    pwm_lvl = 2'b00;
    step(20); look(0, 1, "R10 low side on, no zero current");
    pwm_lvl = 2'b10;
    step(HOLD - 1); look(0, 1, "R10 before hold-off");
    step(1); look(0, 0, "R10 tri cuts low side");
    step(5);
    finish_run();
  end
endmodule